// File: doc/BRIEF.md
# I2C Target Address Recogniser with Don't-Care Mask

This block decides whether an address arriving on an I2C bus is meant for the local target. A bit-level receiver upstream assembles each byte and presents it here with a one-cycle `byte_vld` strobe. It also says whether the byte is the first byte after a start condition or the byte that follows it. The recogniser compares the byte with a programmed own address. The comparison treats any position whose mask bit is 1 as a don't-care. The result is a registered match (acknowledge) flag, a general-call flag and the captured read/write bit.

A fixed set of reserved addresses can never be recognised, whatever the mask. The all-zero write address (general call) is recognised only when it is separately enabled. In 10-bit mode the first byte must carry the 10-bit header prefix together with the two upper address bits. The byte after it carries the lower eight bits. Match rises only once both bytes agree. A mask-bypass input stands for the peripheral-management mode in which masking is not allowed. When it is set, every address bit must match exactly.

Top module: `i2c_addr_match`

## Requirements
- R1: On a first byte, bits 7:1 form the 7-bit address and bit 0 the R/W bit. In 7-bit mode, a non-reserved address matches when it equals `own_addr[6:0]` on every position where `addr_mask[6:0]` is 0; positions with mask 1 are don't-care.
- R2: When `mask_bypass` is 1 the mask is treated as all zeros, so an exact compare is required.
- R3: The 7-bit addresses 0000001, 000001x, 00001xx and 11111xx never set `addr_match`, whatever the own address and mask.
- R4: Address 0000000 with R/W = 1 never sets `addr_match` or `gen_call`.
- R5: Address 0000000 with R/W = 0 sets both `addr_match` and `gen_call` when `gc_en` is 1, and neither when `gc_en` is 0; `gen_call` is never 1 without `addr_match`.
- R6: In 7-bit mode the header pattern 11110xx never matches.
- R7: In 10-bit mode, a first byte whose address bits 7:3 are 11110 is accepted as a header when its bits 2:1 equal `own_addr[9:8]` under `addr_mask[9:8]`. A later byte with `second_byte` = 1 then sets `addr_match` exactly when all eight of its bits equal `own_addr[7:0]` under `addr_mask[7:0]` and the header was accepted.
- R8: In 10-bit mode a first byte alone never sets `addr_match`, except as a general call (R5).
- R9: Outputs change only in the cycle after a clock edge at which `byte_vld` or `start_det` was 1, and otherwise hold.
- R10: `start_det` clears `addr_match`, `gen_call`, `rw_bit` and any accepted header, and takes priority over a simultaneous `byte_vld`.
- R11: `rw_bit` takes bit 0 of each first byte; a second byte leaves it unchanged.
- R12: In 7-bit mode a byte with `second_byte` = 1 changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_det | input | 1 | Start (or repeated start) seen; clears state |
| byte_vld | input | 1 | One-cycle strobe: `rx_byte` is complete |
| second_byte | input | 1 | 0 = first byte after start, 1 = following byte |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| own_addr | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| addr_mask | input | 10 | 1 = address position is don't-care |
| mode_10b | input | 1 | 1 = 10-bit addressing |
| gc_en | input | 1 | General-call acceptance enable |
| mask_bypass | input | 1 | 1 = ignore the mask (exact compare) |
| addr_match | output | 1 | Registered match / acknowledge |
| gen_call | output | 1 | Registered general-call flag |
| rw_bit | output | 1 | R/W bit captured from the first byte |

## Verification
The assertions assume that `byte_vld` is a single-cycle strobe and that `second_byte` and `rx_byte` are stable while it is high. They also assume that the configuration inputs do not change in the cycle a byte is taken. The bench drives every input on the falling edge and raises `byte_vld` for exactly one cycle per byte. It sets the configuration only while no byte is in flight, and issues a start before each address sequence, as a real bus receiver would. Within that envelope, it sweeps every first-byte value in 7-bit mode over several own-address and mask settings. It also sweeps every header and low-byte combination in 10-bit mode.

// File: rtl/i2c_am_pkg.sv
// Package: shared types for the I2C address recogniser.
// Assumes a 7-bit address field in the first byte (bits 7:1) and R/W in bit 0.
package i2c_am_pkg;

    localparam int A7_W = 7;

    // Class of a first byte, decided from its fixed bit patterns only.
    typedef enum logic [2:0] {
        CLS_NORMAL = 3'd0,
        CLS_GCALL  = 3'd1,
        CLS_START  = 3'd2,
        CLS_RSVD   = 3'd3,
        CLS_HDR10  = 3'd4
    } addr_class_e;

endpackage

// File: rtl/am_classify.sv
// Module: am_classify
// Sorts a first byte into general call, start byte, reserved, 10-bit header
// or ordinary address. Purely combinational and independent of the mask.
// Assumes the 7-bit address is the upper seven bits of the byte.
module am_classify
    import i2c_am_pkg::*;
(
    input  logic [A7_W-1:0] a7,
    input  logic            rw,
    output addr_class_e     cls
);

    // Pattern decode: all-zero first, then header, then reserved ranges.
    always_comb begin
        cls = CLS_NORMAL;
        if (a7 == '0) begin
            cls = rw ? CLS_START : CLS_GCALL;
        end else if (a7[6:2] == 5'b11110) begin
            cls = CLS_HDR10;
        end else if ((a7[6:3] == 4'b0000) || (a7[6:2] == 5'b11111)) begin
            cls = CLS_RSVD;
        end
    end

endmodule

// File: rtl/am_mask_cmp.sv
// Module: am_mask_cmp
// Bitwise equality of two W-bit vectors in which any position whose mask bit
// is 1 always counts as equal. Combinational.
module am_mask_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] dc_mask,
    output logic         eq
);

    logic [W-1:0] miss;

    // One miss bit per position: differs and is not masked.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign miss[i] = (a[i] ^ b[i]) & ~dc_mask[i];
    end

    assign eq = ~|miss;

endmodule

// File: rtl/i2c_addr_match.sv
// Module: i2c_addr_match (top)
// Decides whether received address bytes select this target. It applies a
// don't-care mask, reserved-address rules, general-call gating and 10-bit
// two-byte matching.
// Assumes byte_vld is a one-cycle strobe with rx_byte and second_byte stable
// during it. Outputs are registered and valid the cycle after the strobe.
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              byte_vld,
    input  logic              second_byte,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              mode_10b,
    input  logic              gc_en,
    input  logic              mask_bypass,
    output logic              addr_match,
    output logic              gen_call,
    output logic              rw_bit
);

    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] mask_eff;
    logic [A7_W-1:0]   a7;
    logic              eq7, eq_hi, eq_lo;
    addr_class_e       cls;

    logic hdr_ok;
    logic match_n, gc_n, rw_n, hdr_n;

    // Effective mask: bypass mode forbids don't-care positions.
    assign mask_eff = mask_bypass ? '0 : addr_mask;
    assign a7       = rx_byte[BYTE_W-1:1];

    am_classify u_cls (
        .a7  (a7),
        .rw  (rx_byte[0]),
        .cls (cls)
    );

    am_mask_cmp #(.W(A7_W)) u_cmp7 (
        .a       (a7),
        .b       (own_addr[A7_W-1:0]),
        .dc_mask (mask_eff[A7_W-1:0]),
        .eq      (eq7)
    );

    am_mask_cmp #(.W(HI_W)) u_cmp_hi (
        .a       (a7[HI_W-1:0]),
        .b       (own_addr[ADDR_W-1:BYTE_W]),
        .dc_mask (mask_eff[ADDR_W-1:BYTE_W]),
        .eq      (eq_hi)
    );

    am_mask_cmp #(.W(BYTE_W)) u_cmp_lo (
        .a       (rx_byte),
        .b       (own_addr[BYTE_W-1:0]),
        .dc_mask (mask_eff[BYTE_W-1:0]),
        .eq      (eq_lo)
    );

    // Next-state decision for a received byte.
    always_comb begin
        match_n = addr_match;
        gc_n    = gen_call;
        rw_n    = rw_bit;
        hdr_n   = hdr_ok;
        if (!second_byte) begin
            rw_n    = rx_byte[0];
            match_n = 1'b0;
            gc_n    = 1'b0;
            hdr_n   = 1'b0;
            unique case (cls)
                CLS_GCALL: begin
                    match_n = gc_en;
                    gc_n    = gc_en;
                end
                CLS_HDR10:  hdr_n   = mode_10b && eq_hi;
                CLS_NORMAL: match_n = !mode_10b && eq7;
                default:    match_n = 1'b0;
            endcase
        end else if (mode_10b) begin
            match_n = hdr_ok && eq_lo;
            gc_n    = 1'b0;
        end
    end

    // State registers: start clears, a byte strobe loads the decision.
    always_ff @(posedge clk) begin
        if (!rst_n || start_det) begin
            addr_match <= 1'b0;
            gen_call   <= 1'b0;
            rw_bit     <= 1'b0;
            hdr_ok     <= 1'b0;
        end else if (byte_vld) begin
            addr_match <= match_n;
            gen_call   <= gc_n;
            rw_bit     <= rw_n;
            hdr_ok     <= hdr_n;
        end
    end

    // ---------------- assertions ----------------
    logic take_first;
    assign take_first = byte_vld && !start_det && !second_byte;

    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!addr_match && !gen_call && !rw_bit));

    a_r5_gc_implies_match: assert property (@(posedge clk) disable iff (!rst_n)
        gen_call |-> addr_match);

    a_r5_gc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (take_first && !gc_en) |=> !gen_call);

    a_r3_reserved_never: assert property (@(posedge clk) disable iff (!rst_n)
        (take_first && (cls == CLS_RSVD)) |=> !addr_match);

    a_r4_start_byte_never: assert property (@(posedge clk) disable iff (!rst_n)
        (take_first && (cls == CLS_START)) |=> (!addr_match && !gen_call));

    a_r8_first_10b_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        (take_first && mode_10b && (cls != CLS_GCALL)) |=> !addr_match);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !start_det) |=>
            ($stable(addr_match) && $stable(gen_call) && $stable(rw_bit)));

    a_r12_second_7b_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && second_byte && !mode_10b && !start_det) |=>
            ($stable(addr_match) && $stable(gen_call) && $stable(rw_bit)));

endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det = 1'b0, byte_vld = 1'b0, second_byte = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [9:0] own_addr = '0, addr_mask = '0;
    logic       mode_10b = 1'b0, gc_en = 1'b0, mask_bypass = 1'b0;
    logic       addr_match, gen_call, rw_bit;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    i2c_addr_match u_dut (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
        .second_byte(second_byte), .rx_byte(rx_byte), .own_addr(own_addr),
        .addr_mask(addr_mask), .mode_10b(mode_10b), .gc_en(gc_en),
        .mask_bypass(mask_bypass), .addr_match(addr_match),
        .gen_call(gen_call), .rw_bit(rw_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual {match,gc,rw}=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
    endtask

    // Present one byte; returns at the falling edge after the capturing edge.
    task automatic send(logic [7:0] b, logic sec);
        @(negedge clk);
        rx_byte = b; second_byte = sec; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; second_byte = 1'b0;
    endtask

    function automatic logic [2:0] outs();
        return {addr_match, gen_call, rw_bit};
    endfunction

    // Independent 7-bit model: {match, gc}.
    function automatic logic [1:0] model7(logic [6:0] a, logic rw, logic [6:0] own,
                                          logic [6:0] msk, logic gce);
        if (a == 7'd0) return rw ? 2'b00 : {gce, gce};
        if (a < 7'd8) return 2'b00;            // 0000001..0000111
        if (a >= 7'h78) return 2'b00;          // 1111xxx: reserved and header
        return {(((a ^ own) & ~msk) == 7'd0), 1'b0};
    endfunction

    initial begin
        logic [1:0] e;
        logic [2:0] held;
        logic [6:0] o7, m7;
        logic       byp;

        repeat (3) @(negedge clk);
        chk("R10 reset", outs(), 3'b000);
        rst_n = 1'b1;

        // 7-bit sweep over several configurations (R1..R6, R11).
        for (int cfg = 0; cfg < 6; cfg++) begin
            case (cfg)
                0: begin o7 = 7'h00; m7 = 7'h20; byp = 0; end
                1: begin o7 = 7'h55; m7 = 7'h00; byp = 0; end
                2: begin o7 = 7'h55; m7 = 7'h0F; byp = 0; end
                3: begin o7 = 7'h3A; m7 = 7'h41; byp = 0; end
                4: begin o7 = 7'h08; m7 = 7'h7F; byp = 0; end
                default: begin o7 = 7'h2C; m7 = 7'h7F; byp = 1; end
            endcase
            for (int g = 0; g < 2; g++) begin
                @(negedge clk);
                mode_10b = 0; own_addr = {3'b000, o7}; addr_mask = {3'b111, m7};
                mask_bypass = byp; gc_en = g[0];
                for (int v = 0; v < 256; v++) begin
                    do_start();
                    send(v[7:0], 1'b0);
                    e = model7(v[7:1], v[0], o7, byp ? 7'd0 : m7, g[0]);
                    chk(byp ? "R2 bypass" : "R1/R3/R4/R5/R6 7-bit", outs(), {e, v[0]});
                end
            end
        end

        // Stated example: own 0000000, mask 0100000 answers 0100000 (R1).
        @(negedge clk);
        own_addr = 10'h000; addr_mask = 10'h020; mask_bypass = 0; gc_en = 0;
        do_start(); send({7'h20, 1'b0}, 1'b0);
        chk("R1 masked example", outs(), 3'b100);
        // R9: holds with no strobe.
        @(negedge clk); @(negedge clk);
        chk("R9 hold", outs(), 3'b100);
        // R12: second byte in 7-bit mode changes nothing.
        send(8'hFF, 1'b1);
        chk("R12 7-bit second ignored", outs(), 3'b100);
        // R10: start with simultaneous byte strobe clears.
        @(negedge clk);
        rx_byte = {7'h20, 1'b1}; byte_vld = 1; start_det = 1; second_byte = 0;
        @(negedge clk);
        byte_vld = 0; start_det = 0;
        chk("R10 start priority", outs(), 3'b000);

        // 10-bit sweep (R7, R8).
        for (int mk = 0; mk < 2; mk++) begin
            for (int oh = 0; oh < 4; oh++) begin
                @(negedge clk);
                mode_10b = 1; gc_en = 1; mask_bypass = 0;
                own_addr = {oh[1:0], 8'hA5};
                addr_mask = mk[0] ? 10'h203 : 10'h000;
                for (int h = 0; h < 4; h++) begin
                    for (int lo = 0; lo < 256; lo++) begin
                        logic hok, lok;
                        hok = (((h[1:0] ^ oh[1:0]) & ~addr_mask[9:8]) == 2'b00);
                        lok = (((lo[7:0] ^ 8'hA5) & ~addr_mask[7:0]) == 8'h00);
                        do_start();
                        send({5'b11110, h[1:0], 1'b0}, 1'b0);
                        chk("R8 10-bit first byte", outs(), 3'b000);
                        send(lo[7:0], 1'b1);
                        chk("R7 10-bit pair", outs(), {hok && lok, 2'b00});
                    end
                end
            end
        end

        // R11: header with R/W = 1 then a second byte with bit0 = 0.
        @(negedge clk); own_addr = 10'h2A5; addr_mask = 10'h000;
        do_start(); send(8'hF5, 1'b0);
        chk("R11 rw capture", outs(), 3'b001);
        send(8'hA4, 1'b1);
        chk("R11 rw kept on second byte", outs(), 3'b001);
        // R5 in 10-bit mode: general call still accepted as a first byte.
        do_start(); send(8'h00, 1'b0);
        chk("R5 gc in 10-bit", outs(), 3'b110);
        held = outs();
        do_start();
        chk("R10 start clears", outs(), 3'b000);
        // R6: header in 7-bit mode never matches even with full mask.
        @(negedge clk); mode_10b = 0; addr_mask = 10'h3FF; own_addr = 10'h078;
        do_start(); send(8'hF0, 1'b0);
        chk("R6 header in 7-bit", outs(), 3'b000);
        if (held == 3'b110) begin end

        finish_run();
    end

endmodule